// File: doc/BRIEF.md
# CAN Operating Mode Sequencer

This block decides when a CAN protocol engine may run. It watches a freeze request and three low-power requests (disable, doze, stop). The protocol engine supplies a bus-idle indication, a once-per-bit tick and the raw receive line. From these the block drives the bit-rate prescaler enable and the acknowledges that software polls. A freeze or a low-power mode begins only at a safe point, when the engine reports no frame in flight. A freeze is also forced once a bounded number of bit times has passed. Leaving freeze waits for the next bit boundary.

In doze and stop, the block can watch the receive line for a falling (recessive-to-dominant) edge when self wake-up is enabled. In doze such an edge asks for the clocks back at once. In stop the edge only raises the interrupt flag, and the clock request follows when the stop request is released. The self wake-up enable is a small register written through a strobe. It is locked while a wake-capable low-power mode is in effect.

Top module: `can_mode_seq`

## Requirements
- R1: After reset `presc_run` is 1, and `frz_ack`, `lpm_ack`, `clk_resume`, `wake_flag` and `swe` are 0. `frz_ack` is 1 only while `presc_run` is 0.
- R2: With `frz_req` high and `bus_idle` low, `frz_ack` stays 0 and `presc_run` stays 1. In the cycle after `bus_idle` is seen high, `frz_ack` is 1 and `presc_run` is 0.
- R3: If the bus stays busy, freeze is forced after FRZ_BITS `bit_tick` pulses counted from freeze-pending entry. `frz_ack` is 1 one cycle after the clock edge that samples the last such tick, and is still 0 after FRZ_BITS-1 ticks.
- R4: After `frz_req` falls, `frz_ack` stays 1 and `presc_run` stays 0 until the next `bit_tick` is sampled. Both then change together on that edge: `frz_ack` falls and `presc_run` rises.
- R5: A low-power request is accepted only when `bus_idle` is high. `lpm_ack` is 1 and `presc_run` is 0 while the mode is in effect. The mode ends in the cycle after its own request falls.
- R6: A freeze requested during a low-power mode leaves `frz_ack` at 0 until that mode is exited. Freeze entry then proceeds as in R2.
- R7: A wake-up event is a `rx` level that goes from 1 to 0 and stays 0 for two samples in a row after a two-flop synchroniser. A 0 that lasts a single cycle is not an event. Events count only with `swe` set and in doze or stop, never in disable.
- R8: A wake-up event in doze raises `clk_resume`, which stays high until doze ends. The same event sets `wake_flag` only when `wake_ie` is 1.
- R9: A wake-up event in stop sets `wake_flag` when `wake_ie` is 1 and leaves `clk_resume` at 0. When stop ends after such an event, `clk_resume` is high for exactly one cycle.
- R10: A `swe_wr` strobe loads `swe_wdata` into `swe`, except while doze or stop is in effect, when the write is ignored. In disable the write takes effect.
- R11: A `wake_clr` pulse clears `wake_flag`. A wake-up event in the same cycle wins over the clear.
- R12: From the running state, a low-power request takes priority over a freeze request. Among low-power requests, disable takes priority over stop, and stop over doze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frz_req | input | 1 | Freeze request |
| dis_req | input | 1 | Disable low-power request |
| doze_req | input | 1 | Doze low-power request |
| stop_req | input | 1 | Stop low-power request |
| bus_idle | input | 1 | No transmit or receive in progress |
| bit_tick | input | 1 | One-cycle pulse per CAN bit time |
| rx | input | 1 | Raw CAN receive level (1 recessive, 0 dominant) |
| swe_wr | input | 1 | Write strobe for the self wake-up enable |
| swe_wdata | input | 1 | Value written to the self wake-up enable |
| wake_ie | input | 1 | Wake-up interrupt enable |
| wake_clr | input | 1 | Write-one-to-clear pulse for the wake-up flag |
| presc_run | output | 1 | Prescaler run enable |
| frz_ack | output | 1 | Freeze acknowledge |
| lpm_ack | output | 1 | Low-power acknowledge |
| clk_resume | output | 1 | Request to restore the clocks |
| wake_flag | output | 1 | Wake-up interrupt flag |
| swe | output | 1 | Current self wake-up enable |

## Verification
The bench sets FRZ_BITS to 8 instead of the default 178. A forced freeze under a permanently busy bus then takes a few dozen cycles, so the forced entry can be checked against both sides of its tick boundary. All other parameters keep their default values. Under these settings every mode transition, the glitch filter and the stop-exit resume pulse fit in short directed scenarios.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_FRZ_WAIT,
        ST_FROZEN,
        ST_THAW,
        ST_LP_WAIT,
        ST_LOWPWR
    } seq_state_e;

    typedef enum logic [1:0] {
        LPM_NONE,
        LPM_DIS,
        LPM_DOZE,
        LPM_STOP
    } lpm_kind_e;

    typedef struct packed {
        logic presc_run;
        logic frz_ack;
        logic lpm_ack;
    } mode_out_t;

    // disable beats stop, stop beats doze
    function automatic lpm_kind_e pick_lpm(input logic d, input logic s, input logic z);
        if (d)      return LPM_DIS;
        else if (s) return LPM_STOP;
        else if (z) return LPM_DOZE;
        else        return LPM_NONE;
    endfunction

    function automatic logic lpm_live(input lpm_kind_e k, input logic d,
                                      input logic s, input logic z);
        case (k)
            LPM_DIS:  return d;
            LPM_STOP: return s;
            LPM_DOZE: return z;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic mode_out_t decode_state(input seq_state_e st);
        mode_out_t o;
        o.presc_run = (st == ST_RUN) || (st == ST_FRZ_WAIT) || (st == ST_LP_WAIT);
        o.frz_ack   = (st == ST_FROZEN) || (st == ST_THAW);
        o.lpm_ack   = (st == ST_LOWPWR);
        return o;
    endfunction

endpackage

// File: rtl/can_wake_filter.sv
module can_wake_filter (
    input  logic clk,
    input  logic rst,
    input  logic rx,
    output logic edge_det
);
    logic rx_meta, rx_sync, hist1, hist2;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
            hist1   <= 1'b1;
            hist2   <= 1'b1;
        end else begin
            rx_meta <= rx;
            rx_sync <= rx_meta;
            hist1   <= rx_sync;
            hist2   <= hist1;
        end
    end

    // two dominant samples preceded by a recessive one
    assign edge_det = !rx_sync && !hist1 && hist2;

    assert_edge_single_R7: assert property (@(posedge clk) disable iff (rst)
        edge_det |=> !edge_det);

endmodule

// File: rtl/can_frz_watchdog.sv
module can_frz_watchdog #(
    parameter int FRZ_BITS = 178
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic bit_tick,
    output logic expired
);
    localparam int CNT_W = $clog2(FRZ_BITS + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm)
            cnt <= '0;
        else if (bit_tick && !expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = arm && (cnt >= CNT_W'(FRZ_BITS));

    assert_wdog_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRZ_BITS));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int FRZ_BITS = 178
) (
    input  logic clk,
    input  logic rst,
    input  logic frz_req,
    input  logic dis_req,
    input  logic doze_req,
    input  logic stop_req,
    input  logic bus_idle,
    input  logic bit_tick,
    input  logic rx,
    input  logic swe_wr,
    input  logic swe_wdata,
    input  logic wake_ie,
    input  logic wake_clr,
    output logic presc_run,
    output logic frz_ack,
    output logic lpm_ack,
    output logic clk_resume,
    output logic wake_flag,
    output logic swe
);
    seq_state_e state, state_nxt;
    lpm_kind_e  kind_q;
    mode_out_t  mo;
    logic       wd_expired, edge_det;
    logic       any_lp, swe_lock, wake_ok, wake_evt, leaving_lp;
    logic       stop_pend, resume_q, flag_q, swe_q;

    can_frz_watchdog #(.FRZ_BITS(FRZ_BITS)) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .arm      (state == ST_FRZ_WAIT),
        .bit_tick (bit_tick),
        .expired  (wd_expired)
    );

    can_wake_filter u_filt (
        .clk      (clk),
        .rst      (rst),
        .rx       (rx),
        .edge_det (edge_det)
    );

    assign any_lp = dis_req || stop_req || doze_req;

    always_comb begin
        state_nxt = state;
        case (state)
            ST_RUN:
                if (any_lp)       state_nxt = ST_LP_WAIT;
                else if (frz_req) state_nxt = ST_FRZ_WAIT;
            ST_FRZ_WAIT:
                if (!frz_req)                     state_nxt = ST_RUN;
                else if (bus_idle || wd_expired)  state_nxt = ST_FROZEN;
            ST_FROZEN:
                if (!frz_req) state_nxt = ST_THAW;
            ST_THAW:
                if (frz_req)       state_nxt = ST_FROZEN;
                else if (bit_tick) state_nxt = ST_RUN;
            ST_LP_WAIT:
                if (!any_lp)       state_nxt = ST_RUN;
                else if (bus_idle) state_nxt = ST_LOWPWR;
            ST_LOWPWR:
                if (!lpm_live(kind_q, dis_req, stop_req, doze_req))
                    state_nxt = frz_req ? ST_FRZ_WAIT : ST_RUN;
            default: state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RUN;
            kind_q <= LPM_NONE;
        end else begin
            state <= state_nxt;
            if (state == ST_LP_WAIT && state_nxt == ST_LOWPWR)
                kind_q <= pick_lpm(dis_req, stop_req, doze_req);
            else if (state_nxt != ST_LOWPWR)
                kind_q <= LPM_NONE;
        end
    end

    assign swe_lock   = (state == ST_LOWPWR) && (kind_q == LPM_DOZE || kind_q == LPM_STOP);
    assign wake_ok    = swe_lock && swe_q;
    assign wake_evt   = wake_ok && edge_det;
    assign leaving_lp = (state == ST_LOWPWR) && (state_nxt != ST_LOWPWR);

    always_ff @(posedge clk) begin
        if (rst) begin
            swe_q     <= 1'b0;
            flag_q    <= 1'b0;
            stop_pend <= 1'b0;
            resume_q  <= 1'b0;
        end else begin
            if (swe_wr && !swe_lock)
                swe_q <= swe_wdata;

            if (wake_evt && wake_ie) flag_q <= 1'b1;
            else if (wake_clr)       flag_q <= 1'b0;

            if (leaving_lp)                            stop_pend <= 1'b0;
            else if (wake_evt && kind_q == LPM_STOP)   stop_pend <= 1'b1;

            if (leaving_lp)
                resume_q <= stop_pend;
            else if (wake_evt && kind_q == LPM_DOZE)
                resume_q <= 1'b1;
            else if (state != ST_LOWPWR)
                resume_q <= 1'b0;
        end
    end

    assign mo         = decode_state(state);
    assign presc_run  = mo.presc_run;
    assign frz_ack    = mo.frz_ack;
    assign lpm_ack    = mo.lpm_ack;
    assign clk_resume = resume_q;
    assign wake_flag  = flag_q;
    assign swe        = swe_q;

    assert_ack_stopped_R1: assert property (@(posedge clk) disable iff (rst)
        frz_ack |-> !presc_run);

    assert_lp_after_idle_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(lpm_ack) |-> $past(bus_idle));

    assert_no_frz_in_lp_R6: assert property (@(posedge clk) disable iff (rst)
        lpm_ack |-> !frz_ack);

    assert_stop_no_resume_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOWPWR && kind_q == LPM_STOP) |-> !clk_resume);

    assert_swe_locked_R10: assert property (@(posedge clk) disable iff (rst)
        swe_lock |=> $stable(swe_q));

    assert_thaw_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(frz_ack) |-> $past(bit_tick));

endmodule

// File: tb/can_mode_seq_bench.sv
module can_mode_seq_bench;

    localparam int FRZ_BITS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frz_req = 0, dis_req = 0, doze_req = 0, stop_req = 0;
    logic bus_idle = 0, bit_tick = 0, rx = 1;
    logic swe_wr = 0, swe_wdata = 0, wake_ie = 0, wake_clr = 0;
    logic presc_run, frz_ack, lpm_ack, clk_resume, wake_flag, swe;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    can_mode_seq #(.FRZ_BITS(FRZ_BITS)) u_can_mode_seq (
        .clk(clk), .rst(rst), .frz_req(frz_req), .dis_req(dis_req),
        .doze_req(doze_req), .stop_req(stop_req), .bus_idle(bus_idle),
        .bit_tick(bit_tick), .rx(rx), .swe_wr(swe_wr), .swe_wdata(swe_wdata),
        .wake_ie(wake_ie), .wake_clr(wake_clr), .presc_run(presc_run),
        .frz_ack(frz_ack), .lpm_ack(lpm_ack), .clk_resume(clk_resume),
        .wake_flag(wake_flag), .swe(swe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) bit_tick = 1;
        @(negedge clk) bit_tick = 0;
    endtask

    task automatic write_swe(input logic v);
        @(negedge clk) begin swe_wr = 1; swe_wdata = v; end
        @(negedge clk) swe_wr = 0;
    endtask

    task automatic rx_edge();
        @(negedge clk) rx = 0;
        cyc(6);
    endtask

    task automatic test_reset();
        check("R1 presc_run", presc_run, 1);
        check("R1 frz_ack", frz_ack, 0);
        check("R1 lpm_ack", lpm_ack, 0);
        check("R1 clk_resume", clk_resume, 0);
        check("R1 wake_flag", wake_flag, 0);
        check("R1 swe", swe, 0);
    endtask

    task automatic test_freeze_idle();
        @(negedge clk) begin bus_idle = 0; frz_req = 1; end
        cyc(4);
        check("R2 ack while busy", frz_ack, 0);
        check("R2 presc while busy", presc_run, 1);
        bus_idle = 1;
        cyc(1);
        check("R2 ack after idle", frz_ack, 1);
        check("R1 presc stopped", presc_run, 0);
        frz_req = 0;
        cyc(4);
        check("R4 ack held before tick", frz_ack, 1);
        check("R4 presc held before tick", presc_run, 0);
        tick();
        check("R4 ack after tick", frz_ack, 0);
        check("R4 presc after tick", presc_run, 1);
    endtask

    task automatic test_watchdog();
        @(negedge clk) begin bus_idle = 0; frz_req = 1; end
        cyc(2);
        for (int i = 0; i < FRZ_BITS - 1; i++) tick();
        cyc(2);
        check("R3 ack before limit", frz_ack, 0);
        tick();
        cyc(1);
        check("R3 ack at limit", frz_ack, 1);
        frz_req = 0;
        tick();
        check("R4 release after forced", frz_ack, 0);
    endtask

    task automatic test_doze();
        bus_idle = 1;
        write_swe(1);
        check("R10 write in run", swe, 1);
        wake_ie = 1;
        @(negedge clk) begin bus_idle = 0; doze_req = 1; end
        cyc(3);
        check("R5 lpm while busy", lpm_ack, 0);
        bus_idle = 1;
        cyc(1);
        check("R5 lpm entered", lpm_ack, 1);
        check("R5 presc off", presc_run, 0);
        frz_req = 1;
        cyc(3);
        check("R6 freeze deferred", frz_ack, 0);
        write_swe(0);
        check("R10 write ignored in doze", swe, 1);
        @(negedge clk) rx = 0;
        @(negedge clk) rx = 1;
        cyc(6);
        check("R7 glitch flag", wake_flag, 0);
        check("R7 glitch resume", clk_resume, 0);
        rx_edge();
        check("R8 doze resume", clk_resume, 1);
        check("R8 doze flag", wake_flag, 1);
        @(negedge clk) wake_clr = 1;
        @(negedge clk) wake_clr = 0;
        check("R11 flag cleared", wake_flag, 0);
        rx = 1;
        doze_req = 0;
        cyc(1);
        check("R5 lpm released", lpm_ack, 0);
        check("R8 resume drops on exit", clk_resume, 0);
        cyc(1);
        check("R6 freeze after exit", frz_ack, 1);
        frz_req = 0;
        tick();
        check("R4 running again", presc_run, 1);
        // doze with interrupt disabled
        cyc(4);
        wake_ie = 0;
        @(negedge clk) doze_req = 1;
        cyc(2);
        rx_edge();
        check("R8 resume without ie", clk_resume, 1);
        check("R8 no flag without ie", wake_flag, 0);
        rx = 1;
        doze_req = 0;
        cyc(5);
    endtask

    task automatic test_stop();
        int pulses;
        wake_ie = 1;
        @(negedge clk) stop_req = 1;
        cyc(2);
        check("R5 stop entered", lpm_ack, 1);
        write_swe(0);
        check("R10 write ignored in stop", swe, 1);
        rx_edge();
        check("R9 stop flag", wake_flag, 1);
        check("R9 no resume in stop", clk_resume, 0);
        rx = 1;
        cyc(5);
        pulses = 0;
        @(negedge clk) stop_req = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (clk_resume) pulses++;
        end
        check("R9 one resume pulse after stop", pulses, 1);
        @(negedge clk) wake_clr = 1;
        @(negedge clk) wake_clr = 0;
    endtask

    task automatic test_priority();
        @(negedge clk) begin
            bus_idle = 0; dis_req = 1; doze_req = 1; frz_req = 1;
        end
        cyc(3);
        check("R12 nothing while busy", lpm_ack, 0);
        bus_idle = 1;
        cyc(1);
        check("R12 lp over freeze", lpm_ack, 1);
        check("R12 no freeze ack", frz_ack, 0);
        write_swe(0);
        check("R12 disable over doze allows write", swe, 0);
        write_swe(1);
        check("R10 write in disable", swe, 1);
        rx_edge();
        check("R7 no wake in disable", wake_flag, 0);
        rx = 1;
        @(negedge clk) begin dis_req = 0; doze_req = 0; end
        cyc(2);
        check("R6 freeze after disable", frz_ack, 1);
        frz_req = 0;
        tick();
    endtask

    initial begin
        fork
            begin
                cyc(3);
                @(negedge clk) rst = 0;
                test_reset();
                test_freeze_idle();
                test_watchdog();
                test_doze();
                test_stop();
                test_priority();
            end
            begin
                cyc(100000);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule